// File: doc/BRIEF.md
# Processor Clock-Switch Sequencer

This block makes a change of the processor clock frequency safe for the kind of processor fitted. When a switch request arrives, the block first quiesces a processor that has an internal PLL. It can do this in one of two ways. It can drive the active-low stop-clock line and wait for the processor's acknowledge. Or it can hold the processor in reset instead. Once the processor is quiet, the block moves the clock-select line. It then keeps the processor stopped for a settling interval of one millisecond, counted in reference-clock cycles, and releases it.

A processor with a static clock, or one run in double-clock mode, needs none of this. For these the select line moves at once. Double-clock mode remains available, but it is not recommended, because it cannot serve PLL parts. The acknowledge input is a strobe that an external bus-cycle decoder produces. Generating the clocks themselves is left to other logic.

The mode is sampled when a request is accepted and held for the whole sequence. A watchdog limits the wait for the acknowledge. If the limit is reached, the switch goes ahead anyway and a timeout flag is set.

Top module: `clksw_seq`

## Requirements
- R1: After reset, `stpclk_n` is 1, `clk_sel` is 0, `busy` is 0 and `ack_timeout` is 0, and `cpu_rst` equals `ext_rst`.
- R2: `mode` encodes the processor class: 0 is PLL with stop-clock handshake, 1 is PLL with reset-based switching, 2 is static clock and 3 is double-clock. In mode 0, a request sampled while idle drives `stpclk_n` low and `busy` high from that edge onward.
- R3: In mode 0, `clk_sel` takes the latched target on the first clock edge after the request edge at which `stop_ack` is sampled high. This is the only edge of the sequence at which `clk_sel` changes.
- R4: After the edge that changes `clk_sel`, the processor stays stopped (or reset) for exactly HOLD_CYC = CLK_HZ/1000 cycles. It is then released, and `busy` falls on the same edge.
- R5: In mode 0, if no acknowledge is sampled within ACK_WAIT_MAX edges after the request edge, `clk_sel` changes on edge ACK_WAIT_MAX and `ack_timeout` is set. `ack_timeout` stays set until the next accepted request clears it. An acknowledge that arrives in time leaves it at 0.
- R6: In mode 1, `cpu_rst` is raised from the request edge onward and `clk_sel` changes one edge later, with no acknowledge needed. `stpclk_n` stays 1 throughout.
- R7: `cpu_rst` is the OR of `ext_rst` and the internal reset-mode stop, at all times and in every mode.
- R8: In modes 2 and 3, `clk_sel` takes the target on the request edge. `stpclk_n`, `cpu_rst` and `busy` do not change.
- R9: While `busy` is 1, new requests and changes on `mode` or `sw_target` have no effect on the running sequence or on `clk_sel`.
- R10: A `stop_ack` pulse sampled while idle or during the hold interval has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CLK_HZ hertz |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| ext_rst | input | 1 | System reset request, passed through to the processor reset |
| mode | input | 2 | Processor class / switching method (encoding in R2) |
| sw_req | input | 1 | Switch request, sampled while idle |
| sw_target | input | 1 | Requested clock select value |
| stop_ack | input | 1 | Decoded stop-clock acknowledge strobe |
| stpclk_n | output | 1 | Stop-clock request to the processor, active low |
| cpu_rst | output | 1 | Processor reset, active high |
| clk_sel | output | 1 | Frequency select to the clock generator |
| busy | output | 1 | A switch sequence is in progress |
| ack_timeout | output | 1 | Last stop-clock wait ended by the watchdog |

## Verification
A sequencer that is stuck in the wait state shows `stpclk_n` held low. A correct design would leave that state within ACK_WAIT_MAX edges. A hold counter that is off by one moves the rising edge of `stpclk_n` or `cpu_rst` and the fall of `busy` by a cycle, so every output is compared on every cycle of a sequence. If the mode is latched wrongly, the wrong line moves or `clk_sel` changes on the wrong edge. This shows up on the request edge or the edge after it.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    CM_PLL_STOP  = 2'd0,
    CM_PLL_RESET = 2'd1,
    CM_STATIC    = 2'd2,
    CM_DOUBLE    = 2'd3
  } cpu_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/clksw_timer.sv
// Counts consecutive cycles with run high; done flags the LIMIT-th edge.
module clksw_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  assign done = run && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] mode,
  input  logic      sw_req,
  input  logic      sw_target,
  input  logic      stop_ack,
  input  logic      wait_done,
  input  logic      hold_done,
  output logic      run_wait,
  output logic      run_hold,
  output logic      stop_q,
  output cpu_mode_e mode_q,
  output logic      sel_q,
  output logic      timeout_q,
  output logic      busy
);
  seq_state_e state;
  logic       target_q;
  cpu_mode_e  mode_in;
  logic       proceed;

  assign mode_in  = cpu_mode_e'(mode);
  assign run_wait = (state == SQ_WAIT);
  assign run_hold = (state == SQ_HOLD);
  assign busy     = (state != SQ_IDLE);
  assign proceed  = stop_ack || (mode_q == CM_PLL_RESET) || wait_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      stop_q    <= 1'b0;
      mode_q    <= CM_PLL_STOP;
      sel_q     <= 1'b0;
      target_q  <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: if (sw_req) begin
          if (mode_in == CM_STATIC || mode_in == CM_DOUBLE) begin
            sel_q <= sw_target;
          end else begin
            state     <= SQ_WAIT;
            stop_q    <= 1'b1;
            mode_q    <= mode_in;
            target_q  <= sw_target;
            timeout_q <= 1'b0;
          end
        end
        SQ_WAIT: if (proceed) begin
          sel_q <= target_q;
          state <= SQ_HOLD;
          if (mode_q == CM_PLL_STOP && !stop_ack) timeout_q <= 1'b1;
        end
        SQ_HOLD: if (hold_done) begin
          stop_q <= 1'b0;
          state  <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clksw_outmap.sv
module clksw_outmap
  import clksw_pkg::*;
(
  input  logic      stop_q,
  input  cpu_mode_e mode_q,
  input  logic      ext_rst,
  output logic      stpclk_n,
  output logic      cpu_rst
);
  logic via_reset;

  assign via_reset = (mode_q == CM_PLL_RESET);
  assign stpclk_n  = ~(stop_q & ~via_reset);
  assign cpu_rst   = ext_rst | (stop_q & via_reset);
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int CLK_HZ       = 33_000_000,
  parameter int ACK_WAIT_MAX = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst,
  input  logic [1:0] mode,
  input  logic       sw_req,
  input  logic       sw_target,
  input  logic       stop_ack,
  output logic       stpclk_n,
  output logic       cpu_rst,
  output logic       clk_sel,
  output logic       busy,
  output logic       ack_timeout
);
  localparam int HOLD_CYC = CLK_HZ / 1000;

  logic      run_wait, run_hold, wait_done, hold_done, stop_q;
  cpu_mode_e mode_q;

  clksw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sw_req(sw_req),
    .sw_target(sw_target), .stop_ack(stop_ack),
    .wait_done(wait_done), .hold_done(hold_done),
    .run_wait(run_wait), .run_hold(run_hold), .stop_q(stop_q),
    .mode_q(mode_q), .sel_q(clk_sel), .timeout_q(ack_timeout), .busy(busy)
  );

  clksw_timer #(.LIMIT(ACK_WAIT_MAX)) u_wait_tmr (
    .clk(clk), .rst_n(rst_n), .run(run_wait), .done(wait_done)
  );

  clksw_timer #(.LIMIT(HOLD_CYC)) u_hold_tmr (
    .clk(clk), .rst_n(rst_n), .run(run_hold), .done(hold_done)
  );

  clksw_outmap u_outmap (
    .stop_q(stop_q), .mode_q(mode_q), .ext_rst(ext_rst),
    .stpclk_n(stpclk_n), .cpu_rst(cpu_rst)
  );
endmodule

// File: rtl/clksw_seq_chk.sv
module clksw_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_rst,
  input logic [1:0] mode,
  input logic       sw_req,
  input logic       sw_target,
  input logic       stop_ack,
  input logic       stpclk_n,
  input logic       cpu_rst,
  input logic       clk_sel,
  input logic       busy,
  input logic       ack_timeout
);
  assert_stop_means_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stpclk_n |-> busy);

  assert_sel_only_when_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(clk_sel) && busy) |-> (!stpclk_n || cpu_rst));

  assert_release_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stpclk_n) |-> !busy);

  assert_timeout_in_sequence_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_timeout) |-> (busy && !stpclk_n));

  assert_single_method_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stpclk_n |-> (cpu_rst == ext_rst));

  assert_ext_reset_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |-> cpu_rst);

  assert_static_switch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(clk_sel) && !busy) |-> (stpclk_n && (cpu_rst == ext_rst)));
endmodule

bind clksw_seq clksw_seq_chk u_chk (.*);

// File: tb/clksw_seq_bench.sv
`timescale 1ns/1ps
module clksw_seq_bench;
  localparam int CLK_HZ   = 6000;
  localparam int WAIT_MAX = 5;
  localparam int HOLD     = CLK_HZ / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst = 1'b0;
  logic [1:0] mode = 2'd0;
  logic sw_req = 1'b0, sw_target = 1'b0, stop_ack = 1'b0;
  logic stpclk_n, cpu_rst, clk_sel, busy, ack_timeout;

  int checks = 0;
  int errors = 0;
  logic cur_sel = 1'b0;

  always #2.5 clk = ~clk;

  clksw_seq #(.CLK_HZ(CLK_HZ), .ACK_WAIT_MAX(WAIT_MAX)) u_clksw_seq (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .mode(mode),
    .sw_req(sw_req), .sw_target(sw_target), .stop_ack(stop_ack),
    .stpclk_n(stpclk_n), .cpu_rst(cpu_rst), .clk_sel(clk_sel),
    .busy(busy), .ack_timeout(ack_timeout)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One switch sequence. d: edge (after the request edge) at which ack is sampled.
  // disturb: re-request, change mode and ack during hold while busy (R9, R10).
  task automatic run_seq(input int md, input int d, input bit disturb);
    logic tgt = ~cur_sel;
    logic old = cur_sel;
    int s, last;
    bit stopper, to_exp;
    stopper = (md == 0 || md == 1);
    s = (md == 0) ? ((d < WAIT_MAX) ? d : WAIT_MAX) : (md == 1) ? 1 : 0;
    to_exp = (md == 0) && (d > WAIT_MAX);
    last = stopper ? s + HOLD + 1 : 2;
    @(negedge clk);
    mode = 2'(md); sw_target = tgt; sw_req = 1'b1; stop_ack = (d == 0);
    for (int k = 0; k <= last; k++) begin
      bit act;
      @(posedge clk);
      @(negedge clk);
      sw_req = 1'b0; sw_target = tgt;
      stop_ack = (k == d - 1);
      if (disturb && k == 1) begin sw_req = 1'b1; sw_target = ~tgt; mode = 2'd2; end
      if (disturb && k == s + 1) stop_ack = 1'b1;
      act = stopper && (k < s + HOLD);
      chk(md == 0 ? "R2" : (md == 1 ? "R6" : "R8"), "stpclk_n", stpclk_n, ~(act && md == 0));
      chk(md == 1 ? "R6" : "R7", "cpu_rst", cpu_rst, act && md == 1);
      chk(md >= 2 ? "R8" : (disturb ? "R9" : "R3"), "clk_sel", clk_sel, (k >= s) ? tgt : old);
      chk(disturb ? "R10" : "R4", "busy", busy, act);
      if (k >= s) chk("R5", "ack_timeout", ack_timeout, to_exp);
      else        chk("R5", "ack_timeout cleared", ack_timeout, 1'b0);
    end
    stop_ack = 1'b0; sw_req = 1'b0;
    cur_sel = tgt;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "stpclk_n", stpclk_n, 1'b1);
    chk("R1", "busy", busy, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "clk_sel", clk_sel, 1'b0);
    chk("R1", "ack_timeout", ack_timeout, 1'b0);
    chk("R1", "cpu_rst", cpu_rst, 1'b0);
    ext_rst = 1'b1; #1;
    chk("R7", "cpu_rst idle", cpu_rst, 1'b1);
    ext_rst = 1'b0;
    // stray ack while idle (R10)
    stop_ack = 1'b1; @(negedge clk); stop_ack = 1'b0; @(negedge clk);
    chk("R10", "busy after idle ack", busy, 1'b0);
    chk("R10", "stpclk_n after idle ack", stpclk_n, 1'b1);
    // sweep ack delay in stop-clock mode, including watchdog cases (R3, R5)
    for (int d = 1; d <= WAIT_MAX + 2; d++) run_seq(0, d, 1'b0);
    run_seq(0, WAIT_MAX + 3, 1'b0);
    run_seq(0, 2, 1'b0);
    run_seq(0, 2, 1'b1);
    run_seq(1, 0, 1'b0);
    run_seq(1, 0, 1'b1);
    run_seq(2, 0, 1'b0);
    run_seq(3, 0, 1'b0);
    run_seq(2, 0, 1'b0);
    // external reset during a stop-clock sequence (R7)
    @(negedge clk);
    mode = 2'd0; sw_target = ~cur_sel; sw_req = 1'b1;
    @(negedge clk);
    sw_req = 1'b0; ext_rst = 1'b1; #1;
    chk("R7", "cpu_rst with ext_rst during stop", cpu_rst, 1'b1);
    chk("R7", "stpclk_n during stop", stpclk_n, 1'b0);
    ext_rst = 1'b0;
    stop_ack = 1'b1; @(negedge clk); stop_ack = 1'b0;
    repeat (HOLD + 2) @(negedge clk);
    chk("R4", "busy after release", busy, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule